// File: doc/BRIEF.md
# Memory Access Alignment Checker

This block decides, for every memory access presented to it, whether the access breaks an alignment rule, and reports the result as a synchronous abort together with a fault class. A load/store unit or a fetch unit drives it with the low bits of the access address, the access size, whether the access is an instruction fetch or a data access, whether the target memory is of the device type, the current privilege level (0 to 3) and three alignment-check enable bits. It returns a fault flag and a two-bit class that tells the exception logic whether to build a data-alignment or an instruction-alignment syndrome.

The two kinds of access follow different rules. An instruction fetch must always sit on a 4-byte boundary, and nothing can relax that rule. A misaligned data access to device memory always faults. A misaligned data access to normal memory faults only when checking is enabled for the privilege level in force. Privilege levels 0 and 1 share one enable, and levels 2 and 3 each have their own. The decision logic is purely combinational. A parameter places a register stage on the outputs when the surrounding pipeline needs one. The block does not translate addresses and does not produce memory attributes.

Top module: `align_checker`

## Requirements
- R1: A misaligned data access to normal memory (`acc_device`=0) faults with class data (code 01) only when the enable bit selected for the current level is 1, and does not fault when that bit is 0.
- R2: The enable bit is selected by level: `chk_en[0]` for levels 0 and 1, `chk_en[1]` for level 2, `chk_en[2]` for level 3. The bits that belong to other levels have no effect on the result.
- R3: A misaligned data access to device memory (`acc_device`=1) always faults with class data (code 01), whatever the value of `chk_en`.
- R4: An instruction fetch (`acc_fetch`=1) faults with class fetch (code 10) exactly when `acc_ofs[1:0]` is non-zero. This holds whatever the size, memory type and enables are.
- R5: Size code n (0 to 4) means an access of 2^n bytes. Such an access is aligned when the n lowest bits of `acc_ofs` are zero. Codes 5 to 7 are treated as code 4 (16 bytes).
- R6: A data access with size code 0 (one byte) never faults.
- R7: When `acc_valid` is 0, there is no fault and the class is 00.
- R8: With `REG_OUT`=1, the outputs show the verdict for the inputs sampled at the previous rising clock edge, and they read 0/00 while `rst_n` is low. With `REG_OUT`=0, the outputs follow the inputs within the same cycle.
- R9: The class encoding is 00 for no fault, 01 for data alignment and 10 for fetch alignment. `flt_valid` is 1 exactly when the class is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_ofs | input | SIZE_MAX_LOG2 (4) | Low address bits of the access |
| acc_size | input | SZ_W (3) | Size code: the access is 2^code bytes |
| acc_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| acc_device | input | 1 | 1 when the target is device memory, 0 for normal memory |
| acc_level | input | 2 | Current privilege level 0 to 3 |
| chk_en | input | 3 | Alignment-check enables: bit 0 for levels 0/1, bit 1 for level 2, bit 2 for level 3 |
| flt_valid | output | 1 | Synchronous abort for an alignment fault |
| flt_class | output | 2 | Fault class: 00 none, 01 data, 10 fetch |

## Verification
The bench builds two copies of the block with SIZE_MAX_LOG2 at its default of 4. One copy uses REG_OUT=1 (instance uut) and the other REG_OUT=0. Both are compared every cycle against one behavioural model, so the same stimulus checks both the same-cycle path and the one-cycle-delayed path. With a 4-bit offset, the 3-bit size code can reach the out-of-range codes 5 to 7. Every offset can then be swept against every size, memory type, level and enable pattern, and this covers the clamp, the byte case and the per-level enable selection exhaustively.

// File: rtl/align_chk_pkg.sv
package align_chk_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_DATA  = 2'b01,
        FLT_FETCH = 2'b10
    } flt_class_e;

    typedef enum logic [1:0] {
        PRIV0 = 2'd0,
        PRIV1 = 2'd1,
        PRIV2 = 2'd2,
        PRIV3 = 2'd3
    } priv_level_e;

    localparam int EN_W = 3;
    localparam int FETCH_ALIGN_LOG2 = 2;

endpackage

// File: rtl/align_chk_mask.sv
module align_chk_mask #(
    parameter int MAX_LOG2 = 4,
    parameter int SZ_W     = 3
) (
    input  logic [MAX_LOG2-1:0] ofs,
    input  logic [SZ_W-1:0]     size_code,
    output logic [SZ_W-1:0]     size_eff,
    output logic                data_mis,
    output logic                fetch_mis
);
    import align_chk_pkg::*;

    localparam int NCODE = MAX_LOG2 + 1;
    localparam logic [SZ_W-1:0] MAX_CODE = SZ_W'(MAX_LOG2);

    logic [NCODE-1:0] mis_tab;

    // one misalignment term per supported size code
    for (genvar k = 0; k < NCODE; k++) begin : g_code
        if (k == 0) begin : g_byte
            assign mis_tab[k] = 1'b0;
        end else begin : g_wide
            assign mis_tab[k] = |ofs[k-1:0];
        end
    end

    always_comb begin
        size_eff = (size_code > MAX_CODE) ? MAX_CODE : size_code;
        data_mis = mis_tab[size_eff];
    end

    assign fetch_mis = |ofs[FETCH_ALIGN_LOG2-1:0];

endmodule

// File: rtl/align_chk_lvl_sel.sv
module align_chk_lvl_sel (
    input  logic [1:0]                       level,
    input  logic [align_chk_pkg::EN_W-1:0]   chk_en,
    output logic                             lvl_en
);
    import align_chk_pkg::*;

    priv_level_e lvl;
    assign lvl = priv_level_e'(level);

    always_comb begin
        lvl_en = 1'b0;
        unique case (lvl)
            PRIV0, PRIV1: lvl_en = chk_en[0];
            PRIV2:        lvl_en = chk_en[1];
            PRIV3:        lvl_en = chk_en[2];
            default:      lvl_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/align_chk_policy.sv
module align_chk_policy #(
    parameter int SZ_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid,
    input  logic                      is_fetch,
    input  logic                      is_device,
    input  logic [SZ_W-1:0]           size_eff,
    input  logic                      data_mis,
    input  logic                      fetch_mis,
    input  logic                      lvl_en,
    output logic                      flt_nxt,
    output align_chk_pkg::flt_class_e cls_nxt
);
    import align_chk_pkg::*;

    always_comb begin
        flt_nxt = 1'b0;
        cls_nxt = FLT_NONE;
        if (valid) begin
            if (is_fetch) begin
                if (fetch_mis) begin
                    flt_nxt = 1'b1;
                    cls_nxt = FLT_FETCH;
                end
            end else if (data_mis && (is_device || lvl_en)) begin
                flt_nxt = 1'b1;
                cls_nxt = FLT_DATA;
            end
        end
    end

    // R4: fetch verdict depends only on the low two offset bits
    p_fetch_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid && is_fetch |-> (flt_nxt == fetch_mis) &&
                              (cls_nxt == (fetch_mis ? FLT_FETCH : FLT_NONE)));

    // R3: device misalignment faults irrespective of enables
    p_device_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !is_fetch && is_device && data_mis |-> flt_nxt && cls_nxt == FLT_DATA);

    // R6: single-byte data accesses never fault
    p_byte_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !is_fetch && size_eff == '0 |-> !flt_nxt);

    // R1: normal memory with checking off never faults
    p_normal_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !is_fetch && !is_device && !lvl_en |-> !flt_nxt);

endmodule

// File: rtl/align_checker.sv
module align_checker #(
    parameter int SIZE_MAX_LOG2 = 4,
    parameter bit REG_OUT       = 1'b1,
    localparam int SZ_W         = $clog2(SIZE_MAX_LOG2 + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    input  logic [SIZE_MAX_LOG2-1:0] acc_ofs,
    input  logic [SZ_W-1:0]          acc_size,
    input  logic                     acc_fetch,
    input  logic                     acc_device,
    input  logic [1:0]               acc_level,
    input  logic [2:0]               chk_en,
    output logic                     flt_valid,
    output logic [1:0]               flt_class
);
    import align_chk_pkg::*;

    logic [SZ_W-1:0] size_eff;
    logic            data_mis;
    logic            fetch_mis;
    logic            lvl_en;
    logic            flt_nxt;
    flt_class_e      cls_nxt;
    flt_class_e      cls_q;

    align_chk_mask #(
        .MAX_LOG2 (SIZE_MAX_LOG2),
        .SZ_W     (SZ_W)
    ) u_mask (
        .ofs       (acc_ofs),
        .size_code (acc_size),
        .size_eff  (size_eff),
        .data_mis  (data_mis),
        .fetch_mis (fetch_mis)
    );

    align_chk_lvl_sel u_lvl (
        .level  (acc_level),
        .chk_en (chk_en),
        .lvl_en (lvl_en)
    );

    align_chk_policy #(
        .SZ_W (SZ_W)
    ) u_policy (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (acc_valid),
        .is_fetch  (acc_fetch),
        .is_device (acc_device),
        .size_eff  (size_eff),
        .data_mis  (data_mis),
        .fetch_mis (fetch_mis),
        .lvl_en    (lvl_en),
        .flt_nxt   (flt_nxt),
        .cls_nxt   (cls_nxt)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flt_valid <= 1'b0;
                cls_q     <= FLT_NONE;
            end else begin
                flt_valid <= flt_nxt;
                cls_q     <= cls_nxt;
            end
        end

        // R7 and R8: idle cycle gives a clean output one cycle later
        p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_valid |=> !flt_valid && flt_class == 2'b00);

        // R8: misaligned fetch appears one cycle later
        p_fetch_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid && acc_fetch && acc_ofs[1:0] != 2'b00
            |=> flt_valid && flt_class == 2'b10);
    end else begin : g_comb
        always_comb begin
            flt_valid = flt_nxt;
            cls_q     = cls_nxt;
        end

        // R7: idle cycle gives a clean output at once
        p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_valid |-> !flt_valid && flt_class == 2'b00);

        // R8: misaligned fetch is reported in the same cycle
        p_fetch_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid && acc_fetch && acc_ofs[1:0] != 2'b00
            |-> flt_valid && flt_class == 2'b10);
    end

    assign flt_class = cls_q;

    // R9: fault flag agrees with the class code, one class at most
    p_class_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid == (flt_class != 2'b00)) && $countones(flt_class) <= 1);

endmodule

// File: tb/align_checker_test.sv
`timescale 1ns/1ps
module align_checker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [3:0] acc_ofs = '0;
    logic [2:0] acc_size = '0;
    logic       acc_fetch = 1'b0;
    logic       acc_device = 1'b0;
    logic [1:0] acc_level = '0;
    logic [2:0] chk_en = '0;

    logic       r_valid, c_valid;
    logic [1:0] r_class, c_class;

    int checks = 0;
    int errors = 0;
    logic [1:0] prev_exp = 2'b00;
    string      prev_tag = "R8";

    always #2 clk = ~clk;

    align_checker #(.SIZE_MAX_LOG2(4), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ofs(acc_ofs),
        .acc_size(acc_size), .acc_fetch(acc_fetch), .acc_device(acc_device),
        .acc_level(acc_level), .chk_en(chk_en),
        .flt_valid(r_valid), .flt_class(r_class)
    );

    align_checker #(.SIZE_MAX_LOG2(4), .REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ofs(acc_ofs),
        .acc_size(acc_size), .acc_fetch(acc_fetch), .acc_device(acc_device),
        .acc_level(acc_level), .chk_en(chk_en),
        .flt_valid(c_valid), .flt_class(c_class)
    );

    // behavioural model of the requirements
    function automatic logic [1:0] model(logic v, logic [3:0] ofs, logic [2:0] sz,
                                         logic f, logic d, logic [1:0] lv, logic [2:0] en);
        int n;
        int bit_idx;
        if (!v) return 2'b00;                                   // R7
        if (f) return (ofs % 4 != 0) ? 2'b10 : 2'b00;           // R4
        n = (sz > 4) ? 4 : int'(sz);                            // R5
        if (n == 0) return 2'b00;                               // R6
        if ((int'(ofs) % (1 << n)) == 0) return 2'b00;
        if (d) return 2'b01;                                    // R3
        bit_idx = (lv <= 1) ? 0 : ((lv == 2) ? 1 : 2);          // R2
        return en[bit_idx] ? 2'b01 : 2'b00;                     // R1
    endfunction

    function automatic string tag_of(logic v, logic [2:0] sz, logic f, logic d, logic [2:0] en);
        if (!v) return "R7";
        if (f) return "R4";
        if (sz > 4) return "R5";
        if (sz == 0) return "R6";
        if (d) return "R3";
        if (en != 3'b000 && en != 3'b111) return "R2";
        return "R1";
    endfunction

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (ofs=%h size=%0d fetch=%b dev=%b lvl=%0d en=%b)",
                     tag, act, exp, acc_ofs, acc_size, acc_fetch, acc_device, acc_level, chk_en);
        end
    endtask

    task automatic step(logic v, logic [3:0] ofs, logic [2:0] sz, logic f,
                        logic d, logic [1:0] lv, logic [2:0] en);
        logic [1:0] exp;
        string      tg;
        @(posedge clk);
        #1;
        acc_valid = v; acc_ofs = ofs; acc_size = sz; acc_fetch = f;
        acc_device = d; acc_level = lv; chk_en = en;
        @(negedge clk);
        exp = model(v, ofs, sz, f, d, lv, en);
        tg  = tag_of(v, sz, f, d, en);
        check(tg, c_class, exp);
        check("R9", {1'b0, c_valid}, {1'b0, exp != 2'b00});
        check({"R8/", prev_tag}, r_class, prev_exp);
        check("R9", {1'b0, r_valid}, {1'b0, prev_exp != 2'b00});
        prev_exp = exp;
        prev_tag = tg;
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // reset state with a faulting access present (R8)
        acc_valid = 1'b1; acc_fetch = 1'b1; acc_ofs = 4'h1;
        repeat (3) @(negedge clk);
        check("R8", r_class, 2'b00);
        check("R8", {1'b0, r_valid}, 2'b00);
        check("R4", c_class, 2'b10);
        acc_valid = 1'b0; acc_fetch = 1'b0; acc_ofs = 4'h0;
        @(posedge clk);
        #1 rst_n = 1'b1;

        // directed corner cases
        step(1, 4'h1, 3'd1, 0, 0, 2'd2, 3'b101);  // R2: other levels' bits ignored
        step(1, 4'h1, 3'd1, 0, 0, 2'd2, 3'b010);  // R2: own bit set
        step(1, 4'h4, 3'd3, 0, 1, 2'd0, 3'b000);  // R3: device, no enables
        step(1, 4'h2, 3'd0, 1, 0, 2'd3, 3'b000);  // R4: fetch, byte size
        step(1, 4'h4, 3'd0, 1, 1, 2'd1, 3'b111);  // R4: aligned fetch
        step(1, 4'h8, 3'd4, 0, 0, 2'd1, 3'b001);  // R5: 16 bytes at 8
        step(1, 4'h8, 3'd7, 0, 1, 2'd0, 3'b000);  // R5: clamped code
        step(1, 4'hF, 3'd0, 0, 1, 2'd3, 3'b111);  // R6: byte on odd address
        step(0, 4'h3, 3'd2, 1, 1, 2'd3, 3'b111);  // R7: no access
        step(1, 4'h2, 3'd2, 0, 0, 2'd0, 3'b110);  // R1: enable off for level 0
        step(1, 4'h2, 3'd2, 0, 0, 2'd1, 3'b001);  // R1: enable on for level 1

        // exhaustive sweep
        for (int s = 0; s < 8; s++)
            for (int o = 0; o < 16; o++)
                for (int fd = 0; fd < 4; fd++)
                    for (int l = 0; l < 4; l++)
                        for (int e = 0; e < 8; e++)
                            step(1, 4'(o), 3'(s), fd[1], fd[0], 2'(l), 3'(e));

        // idle cycles after a faulting access (R7, R8)
        step(1, 4'h3, 3'd2, 1, 0, 2'd0, 3'b000);
        for (int i = 0; i < 4; i++) step(0, 4'(i), 3'd3, 0, 1, 2'd0, 3'b111);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule